// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards a small controller against a stalled program. A free-running counter, clocked by the system oscillator, advances every cycle. If software does not restart it within a fixed window, the block raises a one-cycle reset request. A reset generator elsewhere in the chip takes that request and resets the whole system. With the default parameter, the window is about 700,000 cycles, which is about 0.175 s at 4 MHz. A test build can make the window short.

Software restarts the counter with one bus write: the key byte 0x55 written to the write-only register at offset 0xA. Any other byte written to that offset has no effect. A 0x55 written to any other offset also has no effect. The watchdog runs from every reset onward. There is no way to stop it.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_req` is 0 and the count is cleared. With no restart afterwards, the first request is seen in the cycle after the TIMEOUT-th rising edge at which `rst_n` is high.
- R2: If no restart happens, a request is raised exactly TIMEOUT rising edges after the last restart, whether that restart was a reset or a key write. No input can stop the counting.
- R3: `wdt_rst_req` is high for exactly one cycle. The count returns to zero on the same edge, so with no restart the requests repeat every TIMEOUT edges.
- R4: A bus write (`bus_sel`=1, `bus_wr`=1) of data 0x55 to address 0xA restarts the count. The next request then comes TIMEOUT edges after the edge that captured the write.
- R5: A write to address 0xA with any data other than 0x55 leaves the count unchanged.
- R6: A write of 0x55 to any address other than 0xA leaves the count unchanged.
- R7: A read (`bus_sel`=1, `bus_wr`=0) of address 0xA returns 0x00 on `bus_rdata` and does not restart the count.
- R8: A key write captured on the same edge at which the timeout would happen wins. No request is raised, and the count restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_sel | input | 1 | Peripheral access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, always 0x00 for this write-only register |
| wdt_rst_req | output | 1 | One-cycle system reset request on timeout |

## Verification
The hardest case to reach from the ports is a key write that lands on the exact edge at which the timeout would fire. The bench reaches it by stepping its own reference count to one cycle before the terminal edge, then issuing the write, and checks that no request follows. Writes that must be ignored are placed between valid restarts. They show up only as the timing of the next request. The scoreboard's predicted request edges therefore expose any write that wrongly restarts the count.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the keyed watchdog.
// Assumes a byte-wide peripheral data bus.
package wdt_pkg;
    localparam int          BUS_DW       = 8;
    localparam logic [7:0]  SERVICE_KEY  = 8'h55;
    localparam int          SERVICE_OFS  = 'hA;
endpackage

// File: rtl/wdt_bus_decode.sv
// Module: wdt_bus_decode
// Decodes peripheral bus accesses for the watchdog service register.
// Produces a one-cycle service strobe only for a write of the key byte to
// the service offset. Assumes bus signals are synchronous to clk.
module wdt_bus_decode #(
    parameter int         ADDR_W = 4,
    parameter int         OFFSET = wdt_pkg::SERVICE_OFS,
    parameter logic [7:0] KEY    = wdt_pkg::SERVICE_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              service,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFFSET);

    logic hit;

    // Address match for this block's only register.
    always_comb hit = bus_sel && (bus_addr == OFS);

    // Service strobe: a write of the exact key byte only.
    always_comb service = hit && bus_wr && (bus_wdata == KEY);

    // The register is write-only: reads always return zero.
    always_comb rdata = 8'h00;

    AST_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        service |-> (bus_wdata == KEY && bus_addr == OFS)); // R5
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Counts oscillator cycles since the last restart. On reaching the
// terminal count it returns to zero and emits a one-cycle timeout pulse.
// A service strobe restarts it and takes priority over the timeout.
// Assumes TIMEOUT >= 2.
module wdt_counter #(
    parameter int TIMEOUT = 700000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic service,
    output logic timeout
);
    localparam int               CNT_W = $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    // Terminal detect on the current count.
    always_comb at_last = (cnt == LAST);

    // Counter: cleared by reset or service, wraps to zero at terminal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (service || at_last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Timeout pulse: one cycle, suppressed when a service arrives on time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timeout <= 1'b0;
        else
            timeout <= at_last && !service;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R3
    AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (cnt == '0)); // R3
    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> (cnt == '0 && !timeout)); // R4
endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// Watchdog that requests a system reset unless software writes the key
// byte to the service register within TIMEOUT cycles. Always enabled.
// Assumes rst_n is the synchronous system reset that follows any request.
module keyed_watchdog #(
    parameter int ADDR_W  = 4,
    parameter int TIMEOUT = 700000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdt_rst_req
);
    logic service;

    wdt_bus_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .service   (service),
        .rdata     (bus_rdata)
    );

    wdt_counter #(
        .TIMEOUT (TIMEOUT)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .service (service),
        .timeout (wdt_rst_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !wdt_rst_req); // R1
    AST_READ_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> !service); // R7
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 20;
    localparam int MAX_CYC    = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req;

    int checks = 0, errors = 0;
    int cyc = 0;          // rising edges with rst_n high since last reset
    int restart = 0;      // model: edge of last restart
    int pulses = 0;       // requests observed
    int total = 0;
    int q[$];             // expected request edges

    keyed_watchdog #(.ADDR_W(4), .TIMEOUT(T)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
        total <= total + 1;
    end

    task automatic fail(string req, int act, int exp);
        errors++;
        $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    endtask

    // Monitor: pops expected request edges and compares at negedge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst_req) pulses++;
            if (q.size() != 0 && q[0] == cyc) begin
                checks++;
                if (wdt_rst_req !== 1'b1) fail("R2 request missing", 0, 1);
                void'(q.pop_front());
            end else if (wdt_rst_req) begin
                checks++;
                fail("R3 unexpected request", 1, 0);
            end
        end
    end

    // Model: push requests due up to edge 'upto' from the last restart.
    task automatic schedule(int upto);
        while (restart + T <= upto) begin
            q.push_back(restart + T);
            restart += T;
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        schedule(cyc);
    endtask

    task automatic idle(int n);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (n) step();
    endtask

    // One bus access, captured at the next rising edge.
    task automatic access(logic wr, logic [3:0] a, logic [7:0] d);
        step();
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        if (wr && a == 4'hA && d == 8'h55) restart = cyc + 1;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_pulses(int base, int exp, string req);
        checks++;
        if (pulses - base != exp) fail(req, pulses - base, exp);
    endtask

    initial begin
        int b;
        repeat (MAX_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog: bench timed out");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b;
        repeat (3) @(posedge clk);
        #1;
        checks++; if (wdt_rst_req !== 1'b0) fail("R1 reset request", wdt_rst_req, 0);
        rst_n = 1'b1; restart = 0;
        // R1/R2/R3: free run, requests at edges T and 2T.
        b = pulses; idle(2*T + 5); expect_pulses(b, 2, "R3 periodic count");
        // R4: regular servicing holds off the request.
        b = pulses;
        for (int i = 0; i < 5; i++) begin access(1'b1, 4'hA, 8'h55); idle(13); end
        expect_pulses(b, 0, "R4 serviced window");
        // R5: wrong data at the service offset is ignored.
        access(1'b1, 4'hA, 8'h55);
        b = pulses;
        access(1'b1, 4'hA, 8'hAA); access(1'b1, 4'hA, 8'h54);
        access(1'b1, 4'hA, 8'h56); access(1'b1, 4'hA, 8'hD5);
        idle(T);
        expect_pulses(b, 1, "R5 wrong key ignored");
        // R6: key at another offset is ignored.
        access(1'b1, 4'hA, 8'h55);
        b = pulses;
        access(1'b1, 4'h5, 8'h55); access(1'b1, 4'hB, 8'h55);
        idle(T);
        expect_pulses(b, 1, "R6 wrong offset ignored");
        // R7: read returns zero and does not restart.
        access(1'b1, 4'hA, 8'h55);
        b = pulses;
        step(); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'hA; bus_wdata = 8'h55;
        #2; checks++; if (bus_rdata !== 8'h00) fail("R7 read data", bus_rdata, 0);
        step(); bus_sel = 1'b0;
        idle(T);
        expect_pulses(b, 1, "R7 read no restart");
        // R8: key write on the terminal edge wins.
        b = pulses;
        while (cyc != restart + T - 2) step();
        access(1'b1, 4'hA, 8'h55);
        checks++; if (restart != cyc) fail("R8 model alignment", restart, cyc);
        idle(T - 3);
        expect_pulses(b, 0, "R8 coincident service");
        idle(5);
        expect_pulses(b, 1, "R8 restart from service edge");
        // R1: mid-run reset clears the count.
        idle(7);
        step(); rst_n = 1'b0;
        repeat (4) step();
        checks++; if (wdt_rst_req !== 1'b0) fail("R1 request in reset", wdt_rst_req, 0);
        restart = 0; rst_n = 1'b1;
        b = pulses; idle(T + 3); expect_pulses(b, 1, "R1 count cleared by reset");
        checks++; if (q.size() != 0) fail("R2 undelivered requests", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule